// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block collects up to 32 interrupt lines from peripherals and turns them into two request lines for a processor and one wakeup line for its idle logic. Every control word has two word addresses. One address sets the bits written as 1 and the other clears them. Software can therefore change one source's setup with a single write and no read-modify-write sequence. Bits written as 0 are left as they are. For each source, a three-bit detection code chooses among level-high, level-low, rising-edge, falling-edge, either-edge and off. An attach bit connects the source at all. A routing bit picks request line 0 or 1. A mask bit lets the source drive its request line, and a wakeup bit lets it drive the wakeup output.

Each input passes through a two-flop synchronizer before detection. Level codes follow the synchronized input. Edge codes latch a pending bit that stays set until software acknowledges it by clearing the source's mask bit. Two read-only status words show the pending, unmasked sources on each request line, and each request line is the OR of its status word. Two instances cover 64 sources, with the upper instance's requests routed to separate processor inputs.

The register port is a plain single-cycle interface. It has no handshake: a write takes effect at the clock edge where `bus_wr` is high, and read data appears one cycle after `bus_rd`.

Top module: `irq_setclr_ctrl`

## Requirements
- R1: After reset every control word is zero. `req0_o`, `req1_o`, `wake_o` and `bus_rdata` are low.
- R2: Control word k sits at word address 2k for set and 2k+1 for clear. The words are: k=0 code bit 0, k=1 code bit 1, k=2 code bit 2, k=3 route, k=4 attach, k=5 mask, k=6 wakeup. A write to a set address ORs in the write data, a write to a clear address removes the bits written as 1, and bits written as 0 are unchanged. A read of either address returns the word as it stood before any write in the same cycle. `bus_rdata` holds that value in the cycle after `bus_rd` and is zero after a cycle without a read.
- R3: Code {bit2,bit1,bit0} = 3'b101 makes a source pending while its synchronized input is high.
- R4: Code 3'b110 makes a source pending while its synchronized input is low.
- R5: Codes 3'b000, 3'b100 and 3'b111 never make a source pending, whatever the input does.
- R6: A pending, unmasked source with route bit 1 appears in status word 0 (address 16) and with route bit 0 in status word 1 (address 17). `req0_o`/`req1_o` is high exactly when its status word is non-zero.
- R7: A source whose mask bit is 0 never appears in a status word or raises a request line.
- R8: `wake_o` is high when any source is pending with its wakeup bit set, regardless of its mask bit.
- R9: Code 3'b001 latches pending on a rising edge of the synchronized input, and pending stays set after the input falls.
- R10: Code 3'b010 latches pending on a falling edge and ignores rising edges.
- R11: Code 3'b011 latches pending on either edge.
- R12: A source whose attach bit is 0 is never pending. Its edge latch still runs underneath.
- R13: A write of 1 to a source's mask clear address (11) clears its latched edge. If a new edge is detected in the same cycle, the latch stays set.
- R14: An input change reaches the outputs after two clock edges for level codes and after three for edge codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for `bus_addr` |
| bus_rd | input | 1 | Read strobe for `bus_addr` |
| bus_addr | input | AW | Word address |
| bus_wdata | input | N | Write data, one bit per source |
| bus_rdata | output | N | Registered read data |
| irq_in | input | N | Raw interrupt lines, asynchronous |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wakeup request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never X after reset and that `bus_addr` and `bus_wdata` are stable around the clock edge. The bench meets this by driving every input on the falling edge. The set/clear checks assume one write per cycle. The bench's write task issues one access at a time, with idle cycles in between. Interrupt lines change only on falling edges and are held for at least one cycle, so each change reaches the synchronizer and the bench's model counts edges the same way the hardware does.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NREG = 7;

  typedef enum logic [2:0] {
    RG_CODE0  = 3'd0,
    RG_CODE1  = 3'd1,
    RG_CODE2  = 3'd2,
    RG_ROUTE  = 3'd3,
    RG_ATTACH = 3'd4,
    RG_MASK   = 3'd5,
    RG_WAKE   = 3'd6
  } reg_idx_e;

  localparam logic [2:0] CODE_RISE = 3'b001;
  localparam logic [2:0] CODE_FALL = 3'b010;
  localparam logic [2:0] CODE_BOTH = 3'b011;
  localparam logic [2:0] CODE_HIGH = 3'b101;
  localparam logic [2:0] CODE_LOW  = 3'b110;

  localparam int ADDR_STAT0 = 2 * NREG + 2;
  localparam int ADDR_STAT1 = 2 * NREG + 3;
  localparam int ADDR_MASK_CLR = 2 * int'(RG_MASK) + 1;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  stat0,
  input  logic [N-1:0]  stat1,
  output logic [N-1:0]  code0,
  output logic [N-1:0]  code1,
  output logic [N-1:0]  code2,
  output logic [N-1:0]  route,
  output logic [N-1:0]  attach,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  wake_en,
  output logic [N-1:0]  ack_clr,
  output logic [N-1:0]  rdata
);
  localparam logic [AW-1:0] A_MCLR = AW'(ADDR_MASK_CLR);
  localparam logic [AW-1:0] A_ST0  = AW'(ADDR_STAT0);
  localparam logic [AW-1:0] A_ST1  = AW'(ADDR_STAT1);
  localparam logic [AW-1:0] A_TOP  = AW'(2 * NREG);

  logic [N-1:0] bank [NREG];
  logic [N-1:0] rd_val;

  for (genvar g = 0; g < NREG; g++) begin : g_word
    localparam logic [AW-1:0] A_SET = AW'(2 * g);
    localparam logic [AW-1:0] A_CLR = AW'(2 * g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   bank[g] <= '0;
      else if (wr && addr == A_SET) bank[g] <= bank[g] | wdata;
      else if (wr && addr == A_CLR) bank[g] <= bank[g] & ~wdata;
    end
  end

  assign code0   = bank[RG_CODE0];
  assign code1   = bank[RG_CODE1];
  assign code2   = bank[RG_CODE2];
  assign route   = bank[RG_ROUTE];
  assign attach  = bank[RG_ATTACH];
  assign mask    = bank[RG_MASK];
  assign wake_en = bank[RG_WAKE];
  assign ack_clr = (wr && addr == A_MCLR) ? wdata : '0;

  always_comb begin
    rd_val = '0;
    if (addr < A_TOP) begin
      for (int k = 0; k < NREG; k++)
        if (addr[AW-1:1] == (AW-1)'(k)) rd_val = bank[k];
    end else if (addr == A_ST0) begin
      rd_val = stat0;
    end else if (addr == A_ST1) begin
      rd_val = stat1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_val : '0;
  end
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
  import irqc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] code0,
  input  logic [N-1:0] code1,
  input  logic [N-1:0] code2,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] pend_raw
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic [2:0] sh;
    logic [2:0] code;
    logic       hit;
    logic       edge_q;
    logic       now_v;
    logic       was_v;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], irq_in[i]};
    end

    assign now_v = sh[1];
    assign was_v = sh[2];
    assign code  = {code2[i], code1[i], code0[i]};
    assign hit   = ((code == CODE_RISE) &&  now_v && !was_v) ||
                   ((code == CODE_FALL) && !now_v &&  was_v) ||
                   ((code == CODE_BOTH) && (now_v != was_v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          edge_q <= 1'b0;
      else if (hit)        edge_q <= 1'b1;
      else if (ack_clr[i]) edge_q <= 1'b0;
    end

    always_comb begin
      case (code)
        CODE_HIGH:                      pend_raw[i] = now_v;
        CODE_LOW:                       pend_raw[i] = !now_v;
        CODE_RISE, CODE_FALL, CODE_BOTH: pend_raw[i] = edge_q;
        default:                        pend_raw[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
  parameter int N = 32
) (
  input  logic [N-1:0] pend_raw,
  input  logic [N-1:0] attach,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] route,
  input  logic [N-1:0] wake_en,
  output logic [N-1:0] stat0,
  output logic [N-1:0] stat1,
  output logic         req0,
  output logic         req1,
  output logic         wake
);
  logic [N-1:0] live;
  logic [N-1:0] armed;

  assign live  = pend_raw & attach;
  assign armed = live & mask;
  assign stat0 = armed & route;
  assign stat1 = armed & ~route;
  assign req0  = |stat0;
  assign req1  = |stat1;
  assign wake  = |(live & wake_en);
endmodule

// File: rtl/irq_setclr_ctrl.sv
module irq_setclr_ctrl #(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  irq_in,
  output logic          req0_o,
  output logic          req1_o,
  output logic          wake_o
);
  logic [N-1:0] code0, code1, code2, route, attach, mask, wake_en;
  logic [N-1:0] ack_clr, pend_raw, stat0, stat1;

  irqc_regs #(.N(N), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .stat0(stat0), .stat1(stat1),
    .code0(code0), .code1(code1), .code2(code2), .route(route),
    .attach(attach), .mask(mask), .wake_en(wake_en), .ack_clr(ack_clr),
    .rdata(bus_rdata)
  );

  irqc_detect #(.N(N)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .code0(code0), .code1(code1), .code2(code2), .ack_clr(ack_clr),
    .pend_raw(pend_raw)
  );

  irqc_route #(.N(N)) u_route (
    .pend_raw(pend_raw), .attach(attach), .mask(mask), .route(route),
    .wake_en(wake_en), .stat0(stat0), .stat1(stat1),
    .req0(req0_o), .req1(req1_o), .wake(wake_o)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int N  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  bus_rdata,
  input logic          req0_o,
  input logic          req1_o,
  input logic          wake_o,
  input logic [N-1:0]  code0,
  input logic [N-1:0]  code1,
  input logic [N-1:0]  code2,
  input logic [N-1:0]  route,
  input logic [N-1:0]  attach,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  wake_en,
  input logic [N-1:0]  pend_raw
);
  localparam logic [AW-1:0] A_MSET = AW'(2 * int'(RG_MASK));
  localparam logic [AW-1:0] A_MCLR = AW'(2 * int'(RG_MASK) + 1);

  logic [N-1:0] dead_code;
  assign dead_code = ~(code2 | code1 | code0) | (code2 & ~(code1 ^ code0));

  always @(posedge clk) begin
    if (!rst_n)
      AST_RESET_QUIET: assert (!req0_o && !req1_o && !wake_o && bus_rdata == '0); // R1
  end

  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSET) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MCLR) |=> ((mask & $past(bus_wdata)) == '0)); // R2

  AST_DEAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_raw & dead_code) == '0)); // R5

  AST_REQ0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    req0_o |-> (|(mask & route & attach & pend_raw))); // R6

  AST_REQ1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    req1_o |-> (|(mask & ~route & attach & pend_raw))); // R7

  AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (|(wake_en & attach & pend_raw))); // R8
endmodule

bind irq_setclr_ctrl irqc_checker #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req0_o(req0_o),
  .req1_o(req1_o), .wake_o(wake_o), .code0(code0), .code1(code1),
  .code2(code2), .route(route), .attach(attach), .mask(mask),
  .wake_en(wake_en), .pend_raw(pend_raw)
);

// File: tb/irq_setclr_ctrl_tb.sv
module irq_setclr_ctrl_tb;
  localparam int N  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic          req0_o, req1_o, wake_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_setclr_ctrl #(.N(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  // ---------------- behavioural reference ----------------
  logic [N-1:0] mreg [7];
  logic [N-1:0] medge;
  logic [N-1:0] mrd;
  logic [N-1:0] hist [$];

  function automatic logic [N-1:0] mpend();
    logic [N-1:0] p;
    p = '0;
    for (int i = 0; i < N; i++) begin
      int c;
      c = {mreg[2][i], mreg[1][i], mreg[0][i]};
      if (c == 5) p[i] = hist[1][i];
      else if (c == 6) p[i] = !hist[1][i];
      else if (c >= 1 && c <= 3) p[i] = medge[i];
    end
    return p & mreg[4];
  endfunction

  function automatic logic [N-1:0] mread(int a);
    if (a < 14) return mreg[a / 2];
    if (a == 16) return mpend() & mreg[5] & mreg[3];
    if (a == 17) return mpend() & mreg[5] & ~mreg[3];
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 7; k++) mreg[k] = '0;
      medge = '0;
      mrd = '0;
      hist.delete();
      for (int k = 0; k < 3; k++) hist.push_back('0);
    end else begin
      logic [N-1:0] setv, clrv;
      setv = '0;
      for (int i = 0; i < N; i++) begin
        int c;
        bit nowb, wasb;
        c = {mreg[2][i], mreg[1][i], mreg[0][i]};
        nowb = hist[1][i];
        wasb = hist[2][i];
        if ((c == 1 && nowb && !wasb) || (c == 2 && !nowb && wasb) ||
            (c == 3 && nowb != wasb)) setv[i] = 1'b1;
      end
      clrv = (bus_wr && bus_addr == 11) ? bus_wdata : '0;
      mrd = bus_rd ? mread(int'(bus_addr)) : '0;
      medge = (medge & ~clrv) | setv;
      if (bus_wr && bus_addr < 14) begin
        if (bus_addr[0] == 1'b0) mreg[bus_addr / 2] = mreg[bus_addr / 2] | bus_wdata;
        else                     mreg[bus_addr / 2] = mreg[bus_addr / 2] & ~bus_wdata;
      end
      hist.push_front(irq_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] p;
      p = mpend();
      chk("R6 model req0", N'(req0_o), N'(|(p & mreg[5] & mreg[3])));
      chk("R6 model req1", N'(req1_o), N'(|(p & mreg[5] & ~mreg[3])));
      chk("R8 model wake", N'(wake_o), N'(|(p & mreg[6])));
      chk("R2 model rdata", bus_rdata, mrd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    @(negedge clk);
  endtask

  task automatic rd(string tag, int a, logic [N-1:0] m, logic [N-1:0] exp);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata & m, exp);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 req0", N'(req0_o), '0);
    chk("R1 req1", N'(req1_o), '0);
    chk("R1 wake", N'(wake_o), '0);
    rd("R1 mask word", 10, '1, '0);
    rd("R1 status1", 17, '1, '0);

    // R2 set/clear aliases
    wr(10, 32'hF0);
    rd("R2 set read", 10, '1, 32'hF0);
    rd("R2 clear alias read", 11, '1, 32'hF0);
    wr(11, 32'h30);
    rd("R2 clear", 10, '1, 32'hC0);
    wr(10, 32'h0);
    rd("R2 zero write", 11, '1, 32'hC0);

    // R3 / R14 level high on source 0, request 0
    wr(0, 32'h1); wr(4, 32'h1); wr(6, 32'h1); wr(8, 32'h1); wr(10, 32'h1);
    irq_in[0] = 1'b1;
    @(negedge clk);
    chk("R14 level one edge", N'(req0_o), '0);
    @(negedge clk);
    chk("R3 level high req0", N'(req0_o), 32'h1);
    rd("R6 status0 bit0", 16, 32'h1, 32'h1);

    // R7 mask gating
    wr(11, 32'h1);
    chk("R7 masked req0", N'(req0_o), '0);
    rd("R7 masked status0", 16, 32'h1, 32'h0);
    wr(10, 32'h1);
    chk("R7 unmasked req0", N'(req0_o), 32'h1);
    wr(11, 32'h1);
    irq_in[0] = 1'b0;

    // R4 level low on source 1, request 1
    wr(2, 32'h2); wr(4, 32'h2); wr(8, 32'h2); wr(10, 32'h2);
    chk("R4 low level req1", N'(req1_o), 32'h1);
    rd("R6 status1 bit1", 17, 32'h2, 32'h2);
    rd("R6 status0 bit1", 16, 32'h2, 32'h0);
    irq_in[1] = 1'b1;
    idle(2);
    chk("R4 high input idle", N'(req1_o), '0);

    // R8 wakeup without mask on source 2
    wr(0, 32'h4); wr(4, 32'h4); wr(8, 32'h4); wr(12, 32'h4);
    chk("R8 wake idle", N'(wake_o), '0);
    irq_in[2] = 1'b1;
    idle(2);
    chk("R8 wake raised", N'(wake_o), 32'h1);
    chk("R7 no req0 unmasked", N'(req0_o), '0);
    chk("R7 no req1 unmasked", N'(req1_o), '0);
    irq_in[2] = 1'b0;
    idle(2);
    chk("R8 wake dropped", N'(wake_o), '0);

    // R5 disabled codes on source 3
    wr(6, 32'h8); wr(8, 32'h8); wr(10, 32'h8);
    irq_in[3] = 1'b1;
    idle(3);
    rd("R5 code 000", 16, 32'h8, 32'h0);
    wr(0, 32'h8); wr(2, 32'h8); wr(4, 32'h8);
    rd("R5 code 111", 16, 32'h8, 32'h0);
    wr(1, 32'h8); wr(3, 32'h8);
    rd("R5 code 100", 16, 32'h8, 32'h0);
    irq_in[3] = 1'b0;
    idle(3);

    // R12 attach gating on source 4
    wr(0, 32'h10); wr(4, 32'h10); wr(6, 32'h10); wr(10, 32'h10);
    irq_in[4] = 1'b1;
    idle(3);
    rd("R12 detached status", 16, 32'h10, 32'h0);
    chk("R12 detached req0", N'(req0_o), '0);
    wr(8, 32'h10);
    rd("R12 attached status", 16, 32'h10, 32'h10);
    irq_in[4] = 1'b0;
    idle(3);

    // R9 / R13 / R14 rising edge on source 5
    wr(0, 32'h20); wr(6, 32'h20); wr(8, 32'h20); wr(10, 32'h20);
    irq_in[5] = 1'b1;
    @(negedge clk);
    irq_in[5] = 1'b0;
    @(negedge clk);
    chk("R14 edge two edges", N'(req0_o), '0);
    @(negedge clk);
    chk("R9 rise latched", N'(req0_o), 32'h1);
    idle(4);
    chk("R9 held after fall", N'(req0_o), 32'h1);
    rd("R9 status0", 16, 32'h20, 32'h20);
    wr(11, 32'h20); wr(10, 32'h20);
    chk("R13 ack req0", N'(req0_o), '0);
    rd("R13 ack status", 16, 32'h20, 32'h0);

    // R10 falling edge on source 6 (mask bit 6 already set)
    wr(2, 32'h40); wr(6, 32'h40); wr(8, 32'h40);
    irq_in[6] = 1'b1;
    idle(4);
    chk("R10 rise ignored", N'(req0_o), '0);
    irq_in[6] = 1'b0;
    idle(4);
    chk("R10 fall latched", N'(req0_o), 32'h1);
    wr(11, 32'h40); wr(10, 32'h40);
    chk("R13 ack fall", N'(req0_o), '0);

    // R11 either edge on source 7, request 1
    wr(0, 32'h80); wr(2, 32'h80); wr(8, 32'h80);
    irq_in[7] = 1'b1;
    idle(4);
    chk("R11 rise latched", N'(req1_o), 32'h1);
    wr(11, 32'h80); wr(10, 32'h80);
    chk("R13 ack both", N'(req1_o), '0);
    irq_in[7] = 1'b0;
    idle(4);
    chk("R11 fall latched", N'(req1_o), 32'h1);
    wr(11, 32'h80); wr(10, 32'h80);
    chk("R13 ack both again", N'(req1_o), '0);

    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule